// File: doc/BRIEF.md
# Double-Buffered Serial Transmit Byte Shifter

This block turns bytes written by a host into a serial bit stream at a programmable bit rate. It has two 8-bit stages in series. The host writes into a holding stage. A shift stage sends the current byte out, most significant bit first. When the shift stage has sent its last bit, it takes the next byte from the holding stage. Both stages reload the alternating pattern 0xAA whenever transmission is not fully enabled. As a result, every transmission opens with two preamble bytes that the host never writes.

Two enables control the block: a data-path enable and a transmitter enable. Bits move only while both are high. Dropping either enable reinitialises the block. A byte that still sits in the holding stage at that moment is therefore lost. To avoid this, the host sends one dummy byte after its last real byte before it drops the transmitter enable. A ready interrupt asks for the next byte. If the shift stage needs a byte and none has been written, it sends the old contents again and raises a sticky underrun flag.

Top module: `tx_byte_shifter`

## Requirements
- R1: While rst_n is low, or while path_en or tx_en is low, both stages hold 0xAA, the holding stage counts as full, ready_irq and underrun are 0, wr_en is ignored, bit_stb stays 0 (rate_div held unchanged), and ser_out shows bit 7 of the shift stage (1).
- R2: While path_en and tx_en are both high, bit_stb is 1 on the last cycle of each bit period. A bit period lasts rate_div+1 clock cycles, and the first one starts on the first enabled cycle.
- R3: Bits leave MSB first. ser_out shows bit 7 of the current byte during its first bit period and bit 7-k during period k. It changes only in the cycle after a bit_stb.
- R4: With no writes after enabling, the first two bytes sent are 0xAA and 0xAA. The first comes from the shift stage and the second from the holding stage.
- R5: ready_irq is 1 exactly when the holding stage is empty. While both enables are high, a write with wr_en loads wr_data into the holding stage, and ready_irq is 0 from the next cycle on.
- R6: On the eighth bit_stb of a byte, the shift stage takes the holding-stage byte and the holding stage becomes empty. The new byte's bit 7 is on ser_out from the next cycle on.
- R7: If the holding stage is empty at the eighth bit_stb, the byte just sent is sent again and underrun goes to 1. underrun stays 1 until an enable drops. A write in that same cycle still fills the holding stage.
- R8: Dropping tx_en while a written byte waits in the holding stage discards that byte. After re-enabling, 0xAA, 0xAA is sent.
- R9: A second write before the holding stage is consumed replaces the first byte. Only the latest byte is sent.
- R10: With rate_div = 0, one bit is sent per clock cycle and bit_stb stays 1.
- R11: If rate_div is lowered below the count already reached in the current bit period, that period ends with bit_stb on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| path_en | input | 1 | Data-path enable |
| tx_en | input | 1 | Transmitter enable |
| rate_div | input | 7 | Bit period minus one, in clock cycles |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to load into the holding stage |
| ser_out | output | 1 | Serial data, MSB first |
| bit_stb | output | 1 | Last cycle of each bit period |
| ready_irq | output | 1 | Holding stage empty |
| underrun | output | 1 | Sticky: a byte was needed and none was written |

## Verification
Only bit_stb is combinational: it reflects the bit counter and rate_div in the same cycle. ser_out, ready_irq and underrun come from registers, so a write, an enable change or the eighth strobe shows up on them in the cycle after the edge that samples it. The reference model in the bench advances at each rising edge with the same inputs. Outputs are compared with it 3 ns after every edge, while inputs change only on falling edges, so each expected value is taken in the cycle where the design is due to show it.

// File: rtl/tx_byte_shifter.sv
module tx_byte_shifter #(
  parameter int BYTE_W = 8,
  parameter int PRE_W = 7,
  parameter logic [BYTE_W-1:0] PREAMBLE = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              path_en,
  input  logic              tx_en,
  input  logic [PRE_W-1:0]  rate_div,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              ser_out,
  output logic              bit_stb,
  output logic              ready_irq,
  output logic              underrun
);
  localparam int IDX_W = $clog2(BYTE_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] shreg, hold;
  logic              hold_full, under_q;
  logic [PRE_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic              active, tick, last;

  assign active = path_en & tx_en;
  assign tick   = active && (cnt >= rate_div);
  assign last   = tick && (idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= PREAMBLE;
      hold      <= PREAMBLE;
      hold_full <= 1'b1;
      under_q   <= 1'b0;
      cnt       <= '0;
      idx       <= '0;
    end else if (!active) begin
      shreg     <= PREAMBLE;
      hold      <= PREAMBLE;
      hold_full <= 1'b1;
      under_q   <= 1'b0;
      cnt       <= '0;
      idx       <= '0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick) idx <= last ? '0 : idx + 1'b1;
      if (last) shreg <= hold;
      else if (tick) shreg <= {shreg[BYTE_W-2:0], 1'b0};
      if (last && !hold_full) under_q <= 1'b1;
      if (wr_en) begin
        hold      <= wr_data;
        hold_full <= 1'b1;
      end else if (last) begin
        hold_full <= 1'b0;
      end
    end
  end

  assign ser_out   = shreg[BYTE_W-1];
  assign bit_stb   = tick;
  assign ready_irq = ~hold_full;
  assign underrun  = under_q;

  // R1: a disabled cycle leaves no request and no error pending
  a_r1_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!ready_irq && !underrun && ser_out));

  // R5: a write fills the holding stage
  a_r5_write_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (active && wr_en) |=> !ready_irq);

  // R6: the holding stage only empties at a bit boundary
  a_r6_ready_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_irq) |-> $past(bit_stb));

  // R7: underrun only when a byte was needed with none waiting
  a_r7_underrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> ($past(bit_stb) && $past(ready_irq)));

  // R7: sticky while enabled
  a_r7_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && active) |=> underrun);

  // R3: the serial bit holds for a whole bit period
  a_r3_hold_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(active) && active && !$past(bit_stb)) |-> $stable(ser_out));
endmodule

// File: tb/tb_tx_byte_shifter.sv
module tb_tx_byte_shifter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic path_en = 1'b0, tx_en = 1'b0, wr_en = 1'b0;
  logic [6:0] rate_div = 7'd3;
  logic [7:0] wr_data = 8'h00;
  logic ser_out, bit_stb, ready_irq, underrun;

  int checks = 0, errors = 0;
  string scen = "R1";

  always #5 clk = ~clk;

  tx_byte_shifter dut (
    .clk(clk), .rst_n(rst_n), .path_en(path_en), .tx_en(tx_en),
    .rate_div(rate_div), .wr_en(wr_en), .wr_data(wr_data),
    .ser_out(ser_out), .bit_stb(bit_stb), .ready_irq(ready_irq), .underrun(underrun)
  );

  // behavioural reference model
  int m_cnt = 0, m_bit = 0;
  logic [7:0] m_cur = 8'hAA;
  logic [7:0] m_q[$];
  logic m_under = 1'b0;
  initial m_q.push_back(8'hAA);

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (scenario %s) t=%0t actual=%b expected=%b", req, scen, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic stb;
    if (!rst_n || !(path_en && tx_en)) begin
      m_cur = 8'hAA; m_q.delete(); m_q.push_back(8'hAA);
      m_bit = 0; m_cnt = 0; m_under = 1'b0;
    end else begin
      stb = (m_cnt >= int'(rate_div));
      m_cnt = stb ? 0 : m_cnt + 1;
      if (stb) begin
        if (m_bit == 7) begin
          m_bit = 0;
          if (m_q.size() > 0) m_cur = m_q.pop_front();
          else m_under = 1'b1;
        end else m_bit++;
      end
      if (wr_en) begin
        if (m_q.size() > 0) m_q[0] = wr_data;
        else m_q.push_back(wr_data);
      end
    end
    #3;
    chk("R3", ser_out, m_cur[7 - m_bit]);
    chk("R2", bit_stb, (path_en && tx_en && (m_cnt >= int'(rate_div))));
    chk("R5", ready_irq, (m_q.size() == 0));
    chk("R7", underrun, m_under);
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(logic [7:0] b);
    while (!ready_irq) @(negedge clk);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=60000 cycles expected=end of stimulus");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state
    step(3);
    chk("R1", ser_out, 1'b1);
    chk("R1", ready_irq, 1'b0);
    chk("R1", underrun, 1'b0);
    rst_n = 1'b1;
    // R1: data path on, transmitter off; writes ignored
    path_en = 1'b1;
    wr_en = 1'b1; wr_data = 8'h3C; step(1); wr_en = 1'b0;
    step(8);
    chk("R1", ready_irq, 1'b0);
    chk("R1", bit_stb, 1'b0);
    // R4, R5, R6: preamble then streamed bytes
    scen = "R4"; tx_en = 1'b1;
    put(8'hC5); scen = "R6"; put(8'h0F); put(8'h96);
    // R7: starve the shifter
    scen = "R7"; step(100);
    chk("R7", underrun, 1'b1);
    put(8'h21); step(40);
    chk("R7", underrun, 1'b1);
    // R8: pending byte is discarded on disable
    scen = "R8"; put(8'h77); tx_en = 1'b0; step(3);
    chk("R8", underrun, 1'b0);
    tx_en = 1'b1; step(80);
    // R9: overwrite before consumption
    scen = "R9";
    while (!ready_irq) @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h12; step(1);
    wr_data = 8'hE4; step(1); wr_en = 1'b0;
    step(70);
    // R10: one bit per clock
    scen = "R10"; path_en = 1'b0; step(2); rate_div = 7'd0; path_en = 1'b1;
    put(8'h81); put(8'h5A); put(8'hFE); step(30);
    // R11: rate lowered mid-period
    scen = "R11"; tx_en = 1'b0; step(2); rate_div = 7'd20; tx_en = 1'b1;
    step(12); rate_div = 7'd2; step(40);
    put(8'hB3); step(60);
    step(2);
    summary();
    $finish;
  end
endmodule